// File: doc/BRIEF.md
# In-Order Retirement Reorder Buffer

This block is the in-order backbone of an out-of-order core. Micro-ops enter at the tail in program order, one per cycle. Each entry gets a tag equal to its slot index. Execution units later report progress on a tag in any order. Entries leave only from the head, in program order, and at most two leave per cycle.

Each entry carries a class, and the class decides what progress makes the entry ready to leave:

- A no-op or zeroing idiom is ready as soon as it is allocated.
- An ALU op or a load is ready once it is reported done. For a load, done means its data has returned.
- A prefetch is ready once its address is known.
- A store is ready once both its address and its data are known.

A fault flag on the head entry, or an interrupt request while the buffer is not empty, discards every live entry. The block then reports the head tag so that exception handling is precise.

The buffer depth bounds how far execution can run ahead of the oldest entry that has not retired. Allocation stops when the buffer is full. Retirement stops at the first entry that is not ready.

Top module: `rob_retire_core`

## Requirements
- R1: After a synchronous reset:
  - the buffer is empty;
  - `alloc_ready` is 1 and `alloc_tag` is 0;
  - `ret_valid` and `flush_valid` are 0.
- R2: A micro-op is accepted on a clock edge where `alloc_valid` and `alloc_ready` are both high. Its tag is the `alloc_tag` shown before that edge. Tags of accepted micro-ops increase by one, modulo DEPTH.
  - Class codes on `alloc_cls`: 0 ALU, 1 no-op/zeroing, 2 load, 3 store, 4 prefetch.
- R3: While DEPTH entries are live, `alloc_ready` is 0. A request made then is dropped and `alloc_tag` does not change.
- R4: Entries retire only from the head and in tag order. The head blocks retirement while it is not ready, even if younger entries are ready.
  - `ret_valid[0]` and `ret_tag0` report the first entry retired on an edge. They are registered, so they are visible in the cycle after that edge.
- R5: Up to two entries retire per edge. The second (`ret_valid[1]`, `ret_tag1` = `ret_tag0`+1) retires only when the first retires on the same edge, and only if it is ready and not faulting.
- R6: A no-op (class 1) is ready at allocation. It can retire on the edge after the edge that accepts it.
- R7: An ALU op or a load becomes ready only after a completion event of kind 0 (done) on its tag. An event of kind 1 (address) does not make it ready.
  - An event on one edge allows retirement on the next edge.
- R8: A store needs both an event of kind 1 (address) and an event of kind 2 (data) before it is ready. Either one alone is not enough.
- R9: A prefetch is ready after an event of kind 1 (address) alone.
- R10: A completion event with `cmp_fault` set marks the entry as faulting. When a faulting entry is at the head, the next edge does the following:
  - it retires nothing;
  - it raises `flush_valid` for one cycle, with `flush_tag` set to the head tag and `flush_irq` = 0;
  - it empties the buffer, so `alloc_tag` then equals `flush_tag`.
- R11: `irq_req` on an edge where the buffer is not empty causes the same flush with `flush_irq` = 1, unless the head is faulting. With an empty buffer, `irq_req` causes no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_cls | input | 3 | Micro-op class code |
| alloc_ready | output | 1 | Buffer can accept this cycle |
| alloc_tag | output | TAG_W | Tag the next accepted micro-op receives |
| cmp_valid | input | 1 | Completion event valid |
| cmp_tag | input | TAG_W | Tag the event refers to |
| cmp_kind | input | 2 | 0 done, 1 address known, 2 data known |
| cmp_fault | input | 1 | Event marks the entry as faulting |
| irq_req | input | 1 | Interrupt request |
| ret_valid | output | 2 | Retire slot valid bits |
| ret_tag0 | output | TAG_W | Tag retired in slot 0 |
| ret_cls0 | output | 3 | Class retired in slot 0 |
| ret_tag1 | output | TAG_W | Tag retired in slot 1 |
| ret_cls1 | output | 3 | Class retired in slot 1 |
| flush_valid | output | 1 | One-cycle flush pulse |
| flush_tag | output | TAG_W | Tag of the head at flush |
| flush_irq | output | 1 | 1 when the flush came from an interrupt |

## Verification
The properties assume two things about the inputs. First, completion events name only tags that are live before the edge. Second, no event names the tag being allocated on the same edge. Under these assumptions the retirement tags can be tracked purely from the output stream.

The random stimulus follows both rules: it picks event tags from the reference model's list of live entries as it stands before each edge. Faults and interrupts are injected rarely, so that long runs of retirement and full-buffer stalls occur between flushes.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [2:0] {
    UC_ALU   = 3'd0,
    UC_NOP   = 3'd1,
    UC_LOAD  = 3'd2,
    UC_STORE = 3'd3,
    UC_PREF  = 3'd4
  } uop_cls_e;

  typedef enum logic [1:0] {
    EV_DONE = 2'd0,
    EV_ADDR = 2'd1,
    EV_DATA = 2'd2
  } cmp_kind_e;

  typedef struct packed {
    logic fault;
    logic data;
    logic addr;
    logic done;
  } ent_stat_t;

  // Readiness by class; a faulting entry is never ready to retire.
  function automatic logic can_retire(input logic [2:0] cls, input ent_stat_t st);
    logic ok;
    case (cls)
      UC_ALU, UC_LOAD: ok = st.done;
      UC_NOP:          ok = 1'b1;
      UC_STORE:        ok = st.addr & st.data;
      UC_PREF:         ok = st.addr;
      default:         ok = 1'b0;
    endcase
    return ok & ~st.fault;
  endfunction

endpackage

// File: rtl/rob_cls_mem.sv
// Class storage: one write port at allocation, two asynchronous read
// ports for the two retire slots (maps to distributed RAM).
module rob_cls_mem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 3,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr0,
  input  logic [AW-1:0]    raddr1,
  output logic [WIDTH-1:0] rdata0,
  output logic [WIDTH-1:0] rdata1
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];

endmodule

// File: rtl/rob_stat_array.sv
// Per-entry progress flags. Completion events set flags; allocation of
// a slot clears them (and presets done for no-ops), winning over events.
module rob_stat_array
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_we,
  input  logic [AW-1:0] alloc_idx,
  input  logic          alloc_nop,
  input  logic          ev_valid,
  input  logic [AW-1:0] ev_idx,
  input  logic [1:0]    ev_kind,
  input  logic          ev_fault,
  input  logic [AW-1:0] rd_idx0,
  input  logic [AW-1:0] rd_idx1,
  output ent_stat_t     rd_stat0,
  output ent_stat_t     rd_stat1
);

  ent_stat_t stat [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        stat[i] <= '0;
      end else if (alloc_we && alloc_idx == AW'(i)) begin
        stat[i].done  <= alloc_nop;
        stat[i].addr  <= 1'b0;
        stat[i].data  <= 1'b0;
        stat[i].fault <= 1'b0;
      end else if (ev_valid && ev_idx == AW'(i)) begin
        if (ev_kind == EV_DONE) stat[i].done <= 1'b1;
        if (ev_kind == EV_ADDR) stat[i].addr <= 1'b1;
        if (ev_kind == EV_DATA) stat[i].data <= 1'b1;
        if (ev_fault)           stat[i].fault <= 1'b1;
      end
    end
  end

  assign rd_stat0 = stat[rd_idx0];
  assign rd_stat1 = stat[rd_idx1];

endmodule

// File: rtl/rob_retire_pick.sv
// Decides, from the two oldest entries, whether this edge flushes or
// retires zero, one or two entries.
module rob_retire_pick
  import rob_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] occ,
  input  logic             irq_req,
  input  logic [2:0]       cls0,
  input  logic [2:0]       cls1,
  input  ent_stat_t        st0,
  input  ent_stat_t        st1,
  output logic             flush_now,
  output logic             flush_is_irq,
  output logic             take0,
  output logic             take1
);

  logic has0, has1, flt0, irq_hit;

  always_comb begin
    has0         = (occ != '0);
    has1         = (occ > CNT_W'(1));
    flt0         = has0 && st0.fault;
    irq_hit      = irq_req && has0;
    flush_now    = flt0 || irq_hit;
    flush_is_irq = !flt0;
    take0        = has0 && !flush_now && can_retire(cls0, st0);
    take1        = take0 && has1 && can_retire(cls1, st1);
  end

endmodule

// File: rtl/rob_retire_core.sv
module rob_retire_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_valid,
  input  logic [2:0]       alloc_cls,
  output logic             alloc_ready,
  output logic [TAG_W-1:0] alloc_tag,
  input  logic             cmp_valid,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic [1:0]       cmp_kind,
  input  logic             cmp_fault,
  input  logic             irq_req,
  output logic [1:0]       ret_valid,
  output logic [TAG_W-1:0] ret_tag0,
  output logic [2:0]       ret_cls0,
  output logic [TAG_W-1:0] ret_tag1,
  output logic [2:0]       ret_cls1,
  output logic             flush_valid,
  output logic [TAG_W-1:0] flush_tag,
  output logic             flush_irq
);

  localparam int CNT_W = TAG_W + 1;

  logic [TAG_W-1:0] head_q, tail_q, head_nx1;
  logic [CNT_W-1:0] occ;
  logic [2:0]       cls0, cls1;
  ent_stat_t        st0, st1;
  logic             flush_now, flush_is_irq, take0, take1, alloc_fire;

  assign head_nx1    = head_q + TAG_W'(1);
  assign alloc_ready = (occ != CNT_W'(DEPTH)) && !flush_now;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_q;

  rob_cls_mem #(.DEPTH(DEPTH), .WIDTH(3)) u_cls (
    .clk    (clk),
    .we     (alloc_fire),
    .waddr  (tail_q),
    .wdata  (alloc_cls),
    .raddr0 (head_q),
    .raddr1 (head_nx1),
    .rdata0 (cls0),
    .rdata1 (cls1)
  );

  rob_stat_array #(.DEPTH(DEPTH)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .alloc_we  (alloc_fire),
    .alloc_idx (tail_q),
    .alloc_nop (alloc_cls == UC_NOP),
    .ev_valid  (cmp_valid),
    .ev_idx    (cmp_tag),
    .ev_kind   (cmp_kind),
    .ev_fault  (cmp_fault),
    .rd_idx0   (head_q),
    .rd_idx1   (head_nx1),
    .rd_stat0  (st0),
    .rd_stat1  (st1)
  );

  rob_retire_pick #(.CNT_W(CNT_W)) u_pick (
    .occ          (occ),
    .irq_req      (irq_req),
    .cls0         (cls0),
    .cls1         (cls1),
    .st0          (st0),
    .st1          (st1),
    .flush_now    (flush_now),
    .flush_is_irq (flush_is_irq),
    .take0        (take0),
    .take1        (take1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q      <= '0;
      tail_q      <= '0;
      occ         <= '0;
      ret_valid   <= '0;
      ret_tag0    <= '0;
      ret_tag1    <= '0;
      ret_cls0    <= '0;
      ret_cls1    <= '0;
      flush_valid <= 1'b0;
      flush_tag   <= '0;
      flush_irq   <= 1'b0;
    end else begin
      ret_valid   <= {take1, take0};
      ret_tag0    <= head_q;
      ret_tag1    <= head_nx1;
      ret_cls0    <= cls0;
      ret_cls1    <= cls1;
      flush_valid <= flush_now;
      flush_tag   <= head_q;
      flush_irq   <= flush_is_irq;
      if (flush_now) begin
        tail_q <= head_q;
        occ    <= '0;
      end else begin
        if (alloc_fire) tail_q <= tail_q + TAG_W'(1);
        head_q <= head_q + TAG_W'(take0) + TAG_W'(take1);
        occ    <= occ + CNT_W'(alloc_fire) - CNT_W'(take0) - CNT_W'(take1);
      end
    end
  end

endmodule

// File: rtl/rob_retire_sva.sv
module rob_retire_sva #(
  parameter int DEPTH = 16,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = TAG_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic [1:0]       ret_valid,
  input logic [TAG_W-1:0] ret_tag0,
  input logic [TAG_W-1:0] ret_tag1,
  input logic             flush_valid,
  input logic [TAG_W-1:0] flush_tag,
  input logic [CNT_W-1:0] occ
);

  logic             armed;
  logic [TAG_W-1:0] exp_head;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      exp_head <= '0;
    end else begin
      armed <= 1'b1;
      if (flush_valid) exp_head <= flush_tag;
      else exp_head <= exp_head + TAG_W'(ret_valid[0]) + TAG_W'(ret_valid[1]);
    end
  end

  AST_RET_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    ret_valid[0] |-> ret_tag0 == exp_head); // R4
  AST_PAIR_CONSEC: assert property (@(posedge clk) disable iff (rst)
    ret_valid[1] |-> (ret_valid[0] && ret_tag1 == TAG_W'(ret_tag0 + TAG_W'(1)))); // R5
  AST_FLUSH_EXCL: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> ret_valid == 2'b00); // R10
  AST_FLUSH_AT_HEAD: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> flush_tag == exp_head); // R10
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (occ == '0 && alloc_tag == flush_tag)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH)); // R3
  AST_ALLOC_SEQ: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(alloc_valid && alloc_ready)) |-> alloc_tag == TAG_W'($past(alloc_tag) + TAG_W'(1))); // R2

endmodule

bind rob_retire_core rob_retire_sva #(.DEPTH(DEPTH)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_tag   (alloc_tag),
  .ret_valid   (ret_valid),
  .ret_tag0    (ret_tag0),
  .ret_tag1    (ret_tag1),
  .flush_valid (flush_valid),
  .flush_tag   (flush_tag),
  .occ         (occ)
);

// File: tb/sim_rob_retire_core.sv
module sim_rob_retire_core;
  localparam int CLK_PERIOD = 10;
  localparam int D = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 1'b0, cmp_valid = 1'b0, cmp_fault = 1'b0, irq_req = 1'b0;
  logic [2:0] alloc_cls = '0;
  logic [TW-1:0] cmp_tag = '0;
  logic [1:0] cmp_kind = '0;
  wire alloc_ready, flush_valid, flush_irq;
  wire [TW-1:0] alloc_tag, ret_tag0, ret_tag1, flush_tag;
  wire [1:0] ret_valid;
  wire [2:0] ret_cls0, ret_cls1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_retire_core #(.DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_cls(alloc_cls),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag), .cmp_valid(cmp_valid),
    .cmp_tag(cmp_tag), .cmp_kind(cmp_kind), .cmp_fault(cmp_fault), .irq_req(irq_req),
    .ret_valid(ret_valid), .ret_tag0(ret_tag0), .ret_cls0(ret_cls0),
    .ret_tag1(ret_tag1), .ret_cls1(ret_cls1), .flush_valid(flush_valid),
    .flush_tag(flush_tag), .flush_irq(flush_irq)
  );

  int nchk = 0, nfail = 0;

  // Behavioural reference: list of live tags plus progress flags by tag.
  int q[$];
  int m_cls[D];
  bit m_done[D], m_addr[D], m_data[D], m_flt[D];
  int m_tail = 0;
  int e_rv = 0, e_t0 = 0, e_t1 = 0, e_c0 = 0, e_c1 = 0, e_fv = 0, e_ft = 0, e_fi = 0;

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  function automatic bit m_ready_of(input int t);
    case (m_cls[t])
      0, 2: return m_done[t];
      1: return 1'b1;
      3: return m_addr[t] && m_data[t];
      4: return m_addr[t];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_flushing();
    return (q.size() > 0) && (m_flt[q[0]] || irq_req);
  endfunction

  function automatic bit m_can_alloc();
    return (q.size() < D) && !m_flushing();
  endfunction

  task automatic m_update();
    int cnt = q.size();
    bit ff = (cnt > 0) && m_flt[q[0]];
    bit fl = m_flushing();
    bit rdy = m_can_alloc();
    bit r0 = !fl && cnt > 0 && m_ready_of(q[0]) && !m_flt[q[0]];
    bit r1 = r0 && cnt > 1 && m_ready_of(q[1]) && !m_flt[q[1]];
    e_rv = {30'd0, r1, r0};
    e_fv = fl;
    if (r0) begin e_t0 = q[0]; e_c0 = m_cls[q[0]]; end
    if (r1) begin e_t1 = q[1]; e_c1 = m_cls[q[1]]; end
    if (fl) begin e_ft = q[0]; e_fi = !ff; end
    if (cmp_valid) begin
      if (cmp_kind == 2'd0) m_done[cmp_tag] = 1;
      if (cmp_kind == 2'd1) m_addr[cmp_tag] = 1;
      if (cmp_kind == 2'd2) m_data[cmp_tag] = 1;
      if (cmp_fault) m_flt[cmp_tag] = 1;
    end
    if (r0) void'(q.pop_front());
    if (r1) void'(q.pop_front());
    if (fl) begin
      m_tail = e_ft;
      q.delete();
    end
    if (alloc_valid && rdy) begin
      q.push_back(m_tail);
      m_cls[m_tail] = int'(alloc_cls);
      m_done[m_tail] = (alloc_cls == 3'd1);
      m_addr[m_tail] = 0; m_data[m_tail] = 0; m_flt[m_tail] = 0;
      m_tail = (m_tail + 1) % D;
    end
  endtask

  task automatic set_in(input bit av, input int ac, input bit cv, input int ct,
                        input int ck, input bit cf, input bit iq);
    alloc_valid = av; alloc_cls = 3'(ac);
    cmp_valid = cv; cmp_tag = TW'(ct); cmp_kind = 2'(ck); cmp_fault = cf;
    irq_req = iq;
  endtask

  task automatic idle();
    set_in(0, 0, 0, 0, 0, 0, 0);
  endtask

  // Inputs are set before the call, away from the edge.
  task automatic step();
    #1;
    chk("R3 alloc_ready", int'(alloc_ready), int'(m_can_alloc()));
    chk("R2 alloc_tag", int'(alloc_tag), m_tail);
    @(posedge clk);
    m_update();
    @(negedge clk);
    chk("R4 ret_valid", int'(ret_valid), e_rv);
    if (e_rv[0]) begin
      chk("R4 ret_tag0", int'(ret_tag0), e_t0);
      chk("R4 ret_cls0", int'(ret_cls0), e_c0);
    end
    if (e_rv[1]) begin
      chk("R5 ret_tag1", int'(ret_tag1), e_t1);
      chk("R5 ret_cls1", int'(ret_cls1), e_c1);
    end
    chk("R10 flush_valid", int'(flush_valid), e_fv);
    if (e_fv != 0) begin
      chk("R10 flush_tag", int'(flush_tag), e_ft);
      chk("R11 flush_irq", int'(flush_irq), e_fi);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int t, a;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 alloc_ready", int'(alloc_ready), 1);
    chk("R1 alloc_tag", int'(alloc_tag), 0);
    chk("R1 ret_valid", int'(ret_valid), 0);
    chk("R1 flush_valid", int'(flush_valid), 0);

    // R6: no-op retires on the edge after allocation
    set_in(1, 1, 0, 0, 0, 0, 0); step();
    idle(); step();
    chk("R6 nop retired", int'(ret_valid[0]), 1);
    chk("R6 nop class", int'(ret_cls0), 1);

    // R7: load waits for its done event; address alone is not enough
    t = m_tail;
    set_in(1, 2, 0, 0, 0, 0, 0); step();
    idle();
    repeat (3) begin step(); chk("R7 load held", int'(ret_valid), 0); end
    set_in(0, 0, 1, t, 1, 0, 0); step();
    idle(); step(); chk("R7 load addr only", int'(ret_valid), 0);
    set_in(0, 0, 1, t, 0, 0, 0); step();
    chk("R7 not same edge", int'(ret_valid), 0);
    idle(); step();
    chk("R7 load retired", int'(ret_valid[0]), 1);
    chk("R7 load tag", int'(ret_tag0), t);

    // R8: store needs both address and data
    t = m_tail;
    set_in(1, 3, 0, 0, 0, 0, 0); step();
    set_in(0, 0, 1, t, 2, 0, 0); step();
    idle(); step(); chk("R8 data only", int'(ret_valid), 0);
    set_in(0, 0, 1, t, 1, 0, 0); step();
    idle(); step(); chk("R8 store retired", int'(ret_valid[0]), 1);

    // R9: prefetch needs address alone
    t = m_tail;
    set_in(1, 4, 0, 0, 0, 0, 0); step();
    set_in(0, 0, 1, t, 1, 0, 0); step();
    idle(); step(); chk("R9 prefetch retired", int'(ret_valid[0]), 1);

    // R4/R5: younger done first blocks; then both leave together
    a = m_tail;
    set_in(1, 0, 0, 0, 0, 0, 0); step(); step();
    set_in(0, 0, 1, (a + 1) % D, 0, 0, 0); step();
    idle(); step(); chk("R4 head blocks", int'(ret_valid), 0);
    set_in(0, 0, 1, a, 0, 0, 0); step();
    idle(); step();
    chk("R5 pair retired", int'(ret_valid), 3);
    chk("R5 pair tag0", int'(ret_tag0), a);
    chk("R5 pair tag1", int'(ret_tag1), (a + 1) % D);

    // R3: fill the buffer, then push against it
    for (int i = 0; i < D; i++) begin set_in(1, 0, 0, 0, 0, 0, 0); step(); end
    t = int'(alloc_tag);
    set_in(1, 0, 0, 0, 0, 0, 0); #1;
    chk("R3 full ready", int'(alloc_ready), 0);
    step(); step();
    chk("R3 tag held", int'(alloc_tag), t);

    // R10: fault on head flushes everything
    t = q[0];
    set_in(0, 0, 1, t, 0, 1, 0); step();
    idle(); step();
    chk("R10 flush", int'(flush_valid), 1);
    chk("R10 flush tag", int'(flush_tag), t);
    chk("R10 cause", int'(flush_irq), 0);
    chk("R10 no retire", int'(ret_valid), 0);
    #1;
    chk("R10 tail reset", int'(alloc_tag), t);
    chk("R10 ready", int'(alloc_ready), 1);

    // R11: interrupt with and without live entries
    set_in(1, 0, 0, 0, 0, 0, 0); step();
    set_in(0, 0, 0, 0, 0, 0, 1); step();
    chk("R11 irq flush", int'(flush_valid), 1);
    chk("R11 irq cause", int'(flush_irq), 1);
    step();
    chk("R11 irq empty", int'(flush_valid), 0);

    // Random traffic against the reference model
    for (int n = 0; n < 3000; n++) begin
      bit av = ($urandom_range(0, 9) < 6);
      bit cv = (q.size() > 0) && ($urandom_range(0, 9) < 7);
      int ct = cv ? q[$urandom_range(0, q.size() - 1)] : 0;
      bit cf = cv && ($urandom_range(0, 59) == 0);
      bit iq = ($urandom_range(0, 149) == 0);
      set_in(av, $urandom_range(0, 4), cv, ct, $urandom_range(0, 2), cf, iq);
      step();
    end
    idle(); step();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule